// File: doc/BRIEF.md
# Performance Event Counter Unit

This unit holds two 32-bit event counters, a mode register and two sample registers that record an instruction address and a data address. Software reaches all five through a single-cycle register port addressed by a 10-bit register number. On each clock, the first counter adds the count on one of eight 3-bit event lanes, and the second counter adds one of four 1-bit event lanes. The mode register chooses the lane for each counter. The first counter's lanes carry between zero and four occurrences per cycle, because some pipeline events can happen several times in one clock.

A counter is negative when its top bit is set. When either counter is negative and both interrupt bits in the mode register are on, the unit raises a level interrupt condition. An external enable input masks only the delivered request. The condition stays pending while that enable is low. An optional freeze bit stops both counters as soon as the condition appears, and they stay stopped until the mode register is written again. On the first cycle of the condition, the two sample registers capture the addresses presented on their inputs.

The register port has no flow control. A write takes effect at the next clock edge. Read data is a combinational function of the register number. The port therefore never applies back-pressure, and the unit never stalls the caller. Event lanes are plain per-cycle levels with no handshake, because an event that is not counted in its cycle is lost.

Top module: `evcnt_unit`

## Requirements
- R1: After reset, every register reads 0, and irq_cond and irq_req are low.
- R2: Register numbers: 952 is the mode register, 953 is counter 1, 954 is counter 2, 955 is the instruction sample and 959 is the data sample. When reg_wr is high, the selected register takes reg_wdata at the clock edge. reg_rdata shows the selected register combinationally. Any other number reads 0, and a write to it changes no register.
- R3: When mode bits [2:0] are nonzero, counter 1 adds, on each unfrozen clock, the 3-bit value (0 to 4) on lane k of evt1_lanes. Lane k occupies bits [3k+2:3k], and k is the value of mode bits [2:0]. When the select is 0, counter 1 does not count, and lane 0 is never counted.
- R4: When mode bits [4:3] are nonzero, counter 2 adds evt2_lanes[k] on each unfrozen clock, where k is the value of those bits. When the select is 0, counter 2 does not count.
- R5: A register write to a counter replaces that counter's value, and any increment in the same cycle is discarded.
- R6: irq_cond is high exactly when bit 31 of either counter is 1 and both mode bit 30 (interrupt control) and mode bit 29 (interrupt enable) are 1.
- R7: irq_req is irq_cond gated by ext_int_en. While ext_int_en is low, irq_cond stays pending, and irq_req rises as soon as ext_int_en goes high.
- R8: When mode bit 31 (freeze) is 1, both counters hold from the first clock at which irq_cond is high. They keep holding, even after irq_cond falls, until the mode register is written. Register writes to the counters still apply while the counters are frozen.
- R9: At the clock where irq_cond is high and was low one clock earlier, the instruction and data sample registers load inst_addr and data_addr. A register write to a sample register in that same cycle takes precedence over the capture.
- R10: The counters wrap modulo 2^32 and do not saturate.
- R11: If a counter is written with bit 31 set while both interrupt bits are set, irq_cond is high from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_num | input | 10 | Register number for read and write |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt1_lanes | input | 24 | Eight 3-bit event-count lanes for counter 1 |
| evt2_lanes | input | 4 | Four 1-bit event lanes for counter 2 |
| inst_addr | input | 32 | Instruction address to sample |
| data_addr | input | 32 | Data address to sample |
| ext_int_en | input | 1 | External interrupt enable (delivery mask) |
| irq_cond | output | 1 | Pending interrupt condition |
| irq_req | output | 1 | Delivered interrupt request |

## Verification
The assertions assume that the lane selected for counter 1 never carries a value above 4. That is the only legal range for a multi-occurrence event, and the increment bound check depends on it. The bench draws every counter-1 lane from 0 to 4 and sets individual lanes only to values in that range. The bench drives register writes only at register numbers it chooses deliberately. A cycle-by-cycle model tracks the register contents and compares all of them on every clock, alongside directed checks for overlapping writes, freezing and wrap-around.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int REGNUM_W = 10;
  localparam logic [REGNUM_W-1:0] RN_MODE  = 10'd952;
  localparam logic [REGNUM_W-1:0] RN_CTR1  = 10'd953;
  localparam logic [REGNUM_W-1:0] RN_CTR2  = 10'd954;
  localparam logic [REGNUM_W-1:0] RN_IADDR = 10'd955;
  localparam logic [REGNUM_W-1:0] RN_DADDR = 10'd959;
  // mode register field positions
  localparam int MB_FREEZE  = 31;
  localparam int MB_INTCTL  = 30;
  localparam int MB_INTEN   = 29;
  localparam int MB_SEL1_LO = 0;
  localparam int MB_SEL2_LO = 3;
endpackage

// File: rtl/evcnt_lane_sel.sv
module evcnt_lane_sel #(
  parameter int SEL_W = 3,
  parameter int LW    = 3,
  localparam int LANES = 1 << SEL_W
) (
  input  logic [LANES*LW-1:0] lanes,
  input  logic [SEL_W-1:0]    sel,
  output logic [LW-1:0]       inc
);
  logic [LW-1:0] lane_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lane_arr[g] = lanes[g*LW +: LW];
  end

  // select value zero means the counter is idle
  always_comb begin
    if (sel == '0) inc = '0;
    else           inc = lane_arr[sel];
  end
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
  parameter int W     = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  input  logic             hold,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr)    cnt <= wdata;
    else if (!hold) cnt <= cnt + W'(inc);
  end

  assert_sw_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !hold) |=> cnt == $past(cnt) + W'($past(inc)));

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !hold && cnt == '1 && inc != '0) |=> cnt == W'($past(inc)) - W'(1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && hold) |=> $stable(cnt));
endmodule

// File: rtl/evcnt_irq_ctl.sv
module evcnt_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic neg_any,
  input  logic int_ctl,
  input  logic int_en,
  input  logic freeze_on,
  input  logic mode_wr,
  input  logic ext_en,
  output logic cond,
  output logic req,
  output logic hold,
  output logic capture
);
  logic frozen_q;
  logic cond_q;

  assign cond    = neg_any & int_ctl & int_en;
  assign req     = cond & ext_en;
  assign hold    = freeze_on & (cond | frozen_q);
  assign capture = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      cond_q   <= 1'b0;
    end else begin
      cond_q <= cond;
      if (mode_wr) frozen_q <= 1'b0;
      else         frozen_q <= frozen_q | (freeze_on & cond);
    end
  end

  assert_freeze_engages_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_on && cond && !mode_wr) |=> hold);

  assert_capture_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL1_W = 3,
  parameter int SEL2_W = 2,
  parameter int INC1_W = 3,
  localparam int LANES1 = 1 << SEL1_W,
  localparam int LANES2 = 1 << SEL2_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REGNUM_W-1:0]      reg_num,
  input  logic                     reg_wr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [LANES1*INC1_W-1:0] evt1_lanes,
  input  logic [LANES2-1:0]        evt2_lanes,
  input  logic [DATA_W-1:0]        inst_addr,
  input  logic [DATA_W-1:0]        data_addr,
  input  logic                     ext_int_en,
  output logic                     irq_cond,
  output logic                     irq_req
);
  logic [DATA_W-1:0] mode_q, iaddr_q, daddr_q, ctr1, ctr2;
  logic [INC1_W-1:0] inc1;
  logic [0:0]        inc2;
  logic              hold, capture;

  logic wr_mode, wr_c1, wr_c2, wr_ia, wr_da;
  assign wr_mode = reg_wr && (reg_num == RN_MODE);
  assign wr_c1   = reg_wr && (reg_num == RN_CTR1);
  assign wr_c2   = reg_wr && (reg_num == RN_CTR2);
  assign wr_ia   = reg_wr && (reg_num == RN_IADDR);
  assign wr_da   = reg_wr && (reg_num == RN_DADDR);

  evcnt_lane_sel #(.SEL_W(SEL1_W), .LW(INC1_W)) u_sel1 (
    .lanes(evt1_lanes), .sel(mode_q[MB_SEL1_LO +: SEL1_W]), .inc(inc1));

  evcnt_lane_sel #(.SEL_W(SEL2_W), .LW(1)) u_sel2 (
    .lanes(evt2_lanes), .sel(mode_q[MB_SEL2_LO +: SEL2_W]), .inc(inc2));

  evcnt_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n),
    .neg_any(ctr1[DATA_W-1] | ctr2[DATA_W-1]),
    .int_ctl(mode_q[MB_INTCTL]), .int_en(mode_q[MB_INTEN]),
    .freeze_on(mode_q[MB_FREEZE]), .mode_wr(wr_mode), .ext_en(ext_int_en),
    .cond(irq_cond), .req(irq_req), .hold(hold), .capture(capture));

  evcnt_counter #(.W(DATA_W), .INC_W(INC1_W)) u_ctr1 (
    .clk(clk), .rst_n(rst_n), .wr(wr_c1), .wdata(reg_wdata),
    .hold(hold), .inc(inc1), .cnt(ctr1));

  evcnt_counter #(.W(DATA_W), .INC_W(1)) u_ctr2 (
    .clk(clk), .rst_n(rst_n), .wr(wr_c2), .wdata(reg_wdata),
    .hold(hold), .inc(inc2), .cnt(ctr2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      iaddr_q <= '0;
      daddr_q <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ia)        iaddr_q <= reg_wdata;
      else if (capture) iaddr_q <= inst_addr;
      if (wr_da)        daddr_q <= reg_wdata;
      else if (capture) daddr_q <= data_addr;
    end
  end

  always_comb begin
    case (reg_num)
      RN_MODE:  reg_rdata = mode_q;
      RN_CTR1:  reg_rdata = ctr1;
      RN_CTR2:  reg_rdata = ctr2;
      RN_IADDR: reg_rdata = iaddr_q;
      RN_DADDR: reg_rdata = daddr_q;
      default:  reg_rdata = '0;
    endcase
  end

  // input contract: multi-count events stay within 0..4
  assert_inc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inc1) <= 4);

  assert_req_needs_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((ctr1[DATA_W-1] || ctr2[DATA_W-1]) && mode_q[MB_INTCTL]
                 && mode_q[MB_INTEN] && ext_int_en));

  assert_neg_write_raises_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c1 && reg_wdata[DATA_W-1] && mode_q[MB_INTCTL] && mode_q[MB_INTEN] && !wr_mode)
      |=> irq_cond);

  assert_sample_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !wr_ia) |=> iaddr_q == $past(inst_addr));

  assert_frozen_ctr2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_c2) |=> $stable(ctr2));
endmodule

// File: tb/evcnt_unit_bench.sv
module evcnt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_num = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [23:0] evt1_lanes = '0;
  logic [3:0]  evt2_lanes = '0;
  logic [31:0] inst_addr = '0;
  logic [31:0] data_addr = '0;
  logic        ext_int_en = 1'b0;
  logic        irq_cond, irq_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_mode = '0, m_c1 = '0, m_c2 = '0, m_ia = '0, m_da = '0;
  bit m_frz = 0, m_condq = 0;

  always #10 clk = ~clk;

  evcnt_unit u_evcnt_unit (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt1_lanes(evt1_lanes),
    .evt2_lanes(evt2_lanes), .inst_addr(inst_addr), .data_addr(data_addr),
    .ext_int_en(ext_int_en), .irq_cond(irq_cond), .irq_req(irq_req));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic bit model_cond();
    return (m_c1[31] | m_c2[31]) & m_mode[30] & m_mode[29];
  endfunction

  task automatic read_reg(input logic [9:0] num, output logic [31:0] val);
    reg_wr = 1'b0;
    reg_num = num;
    #1;
    val = reg_rdata;
  endtask

  task automatic compare_all();
    logic [31:0] v;
    check("R6 irq_cond", {31'd0, irq_cond}, {31'd0, model_cond()});
    check("R7 irq_req", {31'd0, irq_req}, {31'd0, model_cond() & ext_int_en});
    read_reg(10'd952, v); check("R2 mode reg", v, m_mode);
    read_reg(10'd953, v); check("R3 counter1", v, m_c1);
    read_reg(10'd954, v); check("R4 counter2", v, m_c2);
    read_reg(10'd955, v); check("R9 inst sample", v, m_ia);
    read_reg(10'd959, v); check("R9 data sample", v, m_da);
    read_reg(10'd956, v); check("R2 unmapped read", v, 32'd0);
  endtask

  // one clock: predict, advance, compare at the falling edge
  task automatic tick();
    bit cond, hold, cap;
    logic [31:0] n_mode, n_c1, n_c2, n_ia, n_da;
    int s1, s2, inc1, inc2;
    bit n_frz;
    cond = model_cond();
    hold = m_mode[31] & (cond | m_frz);
    cap  = cond & ~m_condq;
    s1 = int'(m_mode[2:0]);
    s2 = int'(m_mode[4:3]);
    inc1 = (s1 == 0) ? 0 : int'(evt1_lanes[s1*3 +: 3]);
    inc2 = (s2 == 0) ? 0 : int'(evt2_lanes[s2]);
    n_mode = (reg_wr && reg_num == 10'd952) ? reg_wdata : m_mode;
    n_c1 = (reg_wr && reg_num == 10'd953) ? reg_wdata : hold ? m_c1 : m_c1 + 32'(inc1);
    n_c2 = (reg_wr && reg_num == 10'd954) ? reg_wdata : hold ? m_c2 : m_c2 + 32'(inc2);
    n_ia = (reg_wr && reg_num == 10'd955) ? reg_wdata : cap ? inst_addr : m_ia;
    n_da = (reg_wr && reg_num == 10'd959) ? reg_wdata : cap ? data_addr : m_da;
    n_frz = (reg_wr && reg_num == 10'd952) ? 1'b0 : (m_frz | (m_mode[31] & cond));
    @(posedge clk);
    @(negedge clk);
    m_mode = n_mode; m_c1 = n_c1; m_c2 = n_c2; m_ia = n_ia; m_da = n_da;
    m_frz = n_frz; m_condq = cond;
    compare_all();
  endtask

  task automatic wr_reg(input logic [9:0] num, input logic [31:0] val);
    reg_num = num; reg_wdata = val; reg_wr = 1'b1;
    tick();
  endtask

  task automatic rand_inputs();
    for (int k = 0; k < 8; k++) evt1_lanes[k*3 +: 3] = 3'($urandom_range(0, 4));
    evt2_lanes = 4'($urandom);
    inst_addr = $urandom;
    data_addr = $urandom;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      rand_inputs();
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, frozen_val;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    check("R1 reset irq_cond", {31'd0, irq_cond}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg(10'd953, v); check("R1 counter1 after reset", v, 32'd0);

    // R3: select 0 ignores all lanes, lane 0 included
    evt1_lanes = {8{3'd4}}; evt2_lanes = 4'hF;
    tick(); tick();
    read_reg(10'd953, v); check("R3 select zero idle", v, 32'd0);

    // R3 R4: sel1=3, sel2=2 with random events
    wr_reg(10'd952, 32'h0000_0013);
    run(40);
    // sel1=7 sel2=3
    wr_reg(10'd952, 32'h0000_001F);
    run(30);

    // R5: write collides with increment
    evt1_lanes = {8{3'd4}};
    wr_reg(10'd953, 32'h0000_0100);
    read_reg(10'd953, v); check("R5 write wins over increment", v, 32'h0000_0100);

    // R2: unmapped write leaves everything alone
    wr_reg(10'd960, 32'hDEAD_BEEF);
    wr_reg(10'd951, 32'hDEAD_BEEF);

    // R10: wrap of counter 2
    wr_reg(10'd952, 32'h0000_0008);
    wr_reg(10'd954, 32'hFFFF_FFFF);
    evt2_lanes = 4'b0010;
    tick();
    read_reg(10'd954, v); check("R10 wrap to zero", v, 32'd0);

    // R11 R7 R9: negative write, masked delivery, capture
    wr_reg(10'd952, 32'h6000_0009);
    ext_int_en = 1'b0;
    inst_addr = 32'hA5A5_0001; data_addr = 32'h5A5A_0002;
    wr_reg(10'd954, 32'h8000_0000);
    check("R11 cond after negative write", {31'd0, irq_cond}, 32'd1);
    check("R7 masked request", {31'd0, irq_req}, 32'd0);
    tick();
    read_reg(10'd955, v); check("R9 captured inst addr", v, 32'hA5A5_0001);
    run(5);
    ext_int_en = 1'b1;
    tick();
    check("R7 request after enable", {31'd0, irq_req}, 32'd1);
    wr_reg(10'd954, 32'h0000_0000);
    run(5);

    // R9: software write to sample register wins on the rise cycle
    wr_reg(10'd953, 32'h8000_0000);
    wr_reg(10'd955, 32'h0000_1234);
    read_reg(10'd955, v); check("R9 software write wins", v, 32'h0000_1234);
    wr_reg(10'd953, 32'h0000_0000);

    // R8: freeze
    wr_reg(10'd952, 32'hE000_0009);
    wr_reg(10'd953, 32'h7FFF_FFF8);
    run(12);
    read_reg(10'd953, frozen_val);
    evt1_lanes = {8{3'd4}}; evt2_lanes = 4'hF;
    tick(); tick(); tick();
    read_reg(10'd953, v); check("R8 frozen counter holds", v, frozen_val);
    wr_reg(10'd953, 32'h0000_0000);
    tick(); tick();
    read_reg(10'd953, v); check("R8 stays frozen after cond drops", v, 32'd0);
    wr_reg(10'd952, 32'hE000_0009);
    tick();
    read_reg(10'd953, v); check("R8 mode rewrite resumes counting", v, 32'd4);

    // mixed random traffic with interrupt bits and toggling enable
    wr_reg(10'd952, 32'h6000_000B);
    for (int i = 0; i < 60; i++) begin
      rand_inputs();
      ext_int_en = 1'($urandom);
      if (i % 20 == 5) wr_reg(10'd953, 32'h7FFF_FFF0);
      else tick();
    end

    finish_run();
  end
endmodule